// File: doc/BRIEF.md
# Wake Event Power-Management Register

This block holds the power-management control/status word of a network device and produces the active-low wake request that brings the system out of a sleep state. Three wake strobes come from detectors that are not part of this block: one for a magic-packet match, one for a change of link state and one for a pattern match. Any of them latches a sticky status flag. While software has set the enable bit, that flag pulls the wake output low.

Software reads the 16-bit word on a combinational read port and updates it through a single-cycle write strobe. It clears the status flag by writing a one to that bit, and a zero there leaves the flag alone. The power-state field is written through the same port. Unsupported state codes are dropped. Writes to the power state never disturb the enable or the status bit, so the flag may be cleared before, after or together with the return to the fully-on state.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset the read word is 16'h0000: status 0, enable 0 and power state 00 (fully on). The wake output is high.
- R2: A write loads bit 8 of the write data into the enable bit. The new value appears on the read port in the cycle after the write.
- R3: A pulse on any one of the three wake strobes sets the status bit (bit 15) in the next cycle. This holds in every power state and whether or not the enable bit is set.
- R4: The wake output is low exactly when the enable bit and the status bit are both 1.
- R5: A write with bit 15 at 1 clears the status bit in the next cycle. A write with bit 15 at 0 leaves the status bit unchanged.
- R6: A wake strobe in the same cycle as a clearing write wins, and the status bit stays 1.
- R7: Bits 1:0 hold the power state (00 fully on, 01 and 10 light sleep, 11 deepest sleep). With default parameters only 00 and 11 are accepted, and a write of 01 or 10 leaves the field unchanged.
- R8: A write that changes the power state leaves the status bit alone unless its own bit 15 is 1. One write may clear the status and return to state 00 together.
- R9: Bits 14:9 and 7:2 always read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| regWrEn | input | 1 | Write strobe for the control/status word |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Current control/status word |
| wakeMagic | input | 1 | Magic-packet wake strobe |
| wakeLink | input | 1 | Link-state-change wake strobe |
| wakePattern | input | 1 | Pattern-match wake strobe |
| powerState | output | 2 | Current power state |
| pmeWake_n | output | 1 | Wake request, active low |

## Verification
Each wake strobe is pulsed alone, and all three are also pulsed together. This shows that any single source is enough and that the sources are not confused with one another. The strobes are applied with the enable bit off and on, and in both accepted power states. This separates setting the status flag from driving the output. Writes with bit 15 at one and at zero are issued alone, together with a wake strobe, and combined with power-state changes. These show that clearing is write-one only, that a new wake event wins over a clear, and that state writes do not touch the flag. Writes of the unsupported state codes and of ones in every reserved bit show that those values are filtered out.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int unsigned CSR_W    = 16;
  localparam int unsigned STATE_W  = 2;
  localparam int unsigned EN_BIT   = 8;
  localparam int unsigned STS_BIT  = 15;
  localparam int unsigned NUM_WAKE = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_ON    = 2'b00,
    PS_LITE1 = 2'b01,
    PS_LITE2 = 2'b10,
    PS_DEEP  = 2'b11
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      setSts;
    logic      clrSts;
    logic      loadEn;
    logic      enVal;
    logic      loadState;
    pwrState_t stateVal;
  } pmStrobe_t;
endpackage

// File: rtl/pm_wake_ctrl_control.sv
module pm_wake_ctrl_control
  import pm_wake_pkg::*;
#(
  parameter bit ALLOW_LITE1 = 1'b0,
  parameter bit ALLOW_LITE2 = 1'b0
) (
  input  logic                wrEn,
  input  logic                wrSts,
  input  logic                wrEnBit,
  input  logic [STATE_W-1:0]  wrState,
  input  logic [NUM_WAKE-1:0] wakeVec,
  output pmStrobe_t           strobe
);
  logic wakeAny;
  logic stateOk;
  logic [3:0] allowMask;

  // allowMask[i] is 1 when state code i may be written
  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_allow
      if (gi == 1) begin : g_l1
        assign allowMask[gi] = ALLOW_LITE1;
      end else if (gi == 2) begin : g_l2
        assign allowMask[gi] = ALLOW_LITE2;
      end else begin : g_fixed
        assign allowMask[gi] = 1'b1;
      end
    end
  endgenerate

  assign wakeAny = |wakeVec;
  assign stateOk = allowMask[wrState];

  always_comb begin
    strobe           = '0;
    strobe.setSts    = wakeAny;
    // a new wake event overrides a clearing write
    strobe.clrSts    = wrEn & wrSts & ~wakeAny;
    strobe.loadEn    = wrEn;
    strobe.enVal     = wrEnBit;
    strobe.loadState = wrEn & stateOk;
    strobe.stateVal  = pwrState_t'(wrState);
  end
endmodule

// File: rtl/pm_wake_ctrl_datapath.sv
module pm_wake_ctrl_datapath
  import pm_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pmStrobe_t          strobe,
  output logic [CSR_W-1:0]   rdWord,
  output pwrState_t          stateQ,
  output logic               wakeOut_n
);
  logic stsQ;
  logic enQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stsQ   <= 1'b0;
      enQ    <= 1'b0;
      stateQ <= PS_ON;
    end else begin
      if (strobe.setSts)      stsQ <= 1'b1;
      else if (strobe.clrSts) stsQ <= 1'b0;
      if (strobe.loadEn)      enQ <= strobe.enVal;
      if (strobe.loadState)   stateQ <= strobe.stateVal;
    end
  end

  always_comb begin
    rdWord                = '0;
    rdWord[STS_BIT]       = stsQ;
    rdWord[EN_BIT]        = enQ;
    rdWord[STATE_W-1:0]   = stateQ;
  end

  assign wakeOut_n = ~(enQ & stsQ);
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter bit ALLOW_LITE1 = 1'b0,
  parameter bit ALLOW_LITE2 = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWrEn,
  input  logic [CSR_W-1:0]    regWrData,
  output logic [CSR_W-1:0]    regRdData,
  input  logic                wakeMagic,
  input  logic                wakeLink,
  input  logic                wakePattern,
  output logic [STATE_W-1:0]  powerState,
  output logic                pmeWake_n
);
  pmStrobe_t strobe;
  pwrState_t stateQ;
  logic      unusedWrBits;

  assign unusedWrBits = ^{regWrData[14:9], regWrData[7:2]};

  pm_wake_ctrl_control #(
    .ALLOW_LITE1(ALLOW_LITE1),
    .ALLOW_LITE2(ALLOW_LITE2)
  ) u_ctrl (
    .wrEn    (regWrEn),
    .wrSts   (regWrData[STS_BIT]),
    .wrEnBit (regWrData[EN_BIT]),
    .wrState (regWrData[STATE_W-1:0]),
    .wakeVec ({wakePattern, wakeLink, wakeMagic}),
    .strobe  (strobe)
  );

  pm_wake_ctrl_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rdWord    (regRdData),
    .stateQ    (stateQ),
    .wakeOut_n (pmeWake_n)
  );

  assign powerState = stateQ;
endmodule

// File: rtl/pm_wake_ctrl_checker.sv
module pm_wake_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        regWrEn,
  input logic [15:0] regWrData,
  input logic [15:0] regRdData,
  input logic        wakeMagic,
  input logic        wakeLink,
  input logic        wakePattern,
  input logic [1:0]  powerState,
  input logic        pmeWake_n
);
  logic anyWake;
  logic clrReq;
  logic unusedChkBits;
  assign anyWake = wakeMagic | wakeLink | wakePattern;
  assign clrReq  = regWrEn & regWrData[15];
  assign unusedChkBits = ^regWrData[14:2];

  // R4: output follows enable and status
  assert_wake_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pmeWake_n == !(regRdData[8] && regRdData[15]));

  // R3: any wake source sets the status bit
  assert_wake_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    anyWake |=> regRdData[15]);

  // R5: write-one clears when no wake event
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clrReq && !anyWake) |=> !regRdData[15]);

  // R5, R8: status held without wake or clear
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrReq && !anyWake) |=> $stable(regRdData[15]));

  // R2: enable loaded on write
  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (regRdData[8] == $past(regWrData[8])));

  // R7: unsupported state codes ignored
  assert_state_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && (regWrData[1:0] == 2'b01 || regWrData[1:0] == 2'b10))
      |=> $stable(powerState));

  // R9: reserved bits read zero
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData & 16'h7EFC) == 16'h0000);
endmodule

bind pm_wake_ctrl pm_wake_ctrl_checker u_chk (.*);

// File: tb/pm_wake_ctrl_test.sv
module pm_wake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        wakeMagic = 1'b0;
  logic        wakeLink = 1'b0;
  logic        wakePattern = 1'b0;
  logic [1:0]  powerState;
  logic        pmeWake_n;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int mSts = 0;
  int mEn = 0;
  int mState = 0;

  always #10 clk = ~clk;

  pm_wake_ctrl uut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      mSts <= 0; mEn <= 0; mState <= 0;
    end else begin
      if (wakeMagic || wakeLink || wakePattern) mSts <= 1;
      else if (regWrEn && regWrData[15]) mSts <= 0;
      if (regWrEn) begin
        mEn <= regWrData[8] ? 1 : 0;
        if (regWrData[1:0] == 2'b00 || regWrData[1:0] == 2'b11)
          mState <= int'(regWrData[1:0]);
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    int expRd;
    expRd = (mSts << 15) | (mEn << 8) | mState;
    check(tag, "read word", int'(regRdData), expRd);
    check(tag, "power state", int'(powerState), mState);
    check(tag, "wake out", int'(pmeWake_n), (mEn != 0 && mSts != 0) ? 0 : 1);
  endtask

  // drive at negedge, model and design update at posedge, compare at next negedge
  task automatic step(input logic we, input logic [15:0] d, input logic [2:0] w, input string tag);
    regWrEn = we;
    regWrData = d;
    {wakePattern, wakeLink, wakeMagic} = w;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
    {wakePattern, wakeLink, wakeMagic} = 3'b000;
    compareAll(tag);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset word", int'(regRdData), 0);
    check("R1", "reset out", int'(pmeWake_n), 1);
    compareAll("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2: enable on and off
    step(1, 16'h0100, 3'b000, "R2");
    check("R2", "enable bit", int'(regRdData[8]), 1);
    step(1, 16'h0000, 3'b000, "R2");
    step(1, 16'h0100, 3'b000, "R2");

    // R3, R4: magic wake with enable set
    step(0, 16'h0000, 3'b001, "R3");
    check("R4", "wake low", int'(pmeWake_n), 0);
    step(0, 16'h0000, 3'b000, "R3");
    // R5: clear by write one
    step(1, 16'h8100, 3'b000, "R5");
    check("R5", "cleared word", int'(regRdData), 16'h0100);

    // R3: link wake in deepest state
    step(1, 16'h0103, 3'b000, "R7");
    step(0, 16'h0000, 3'b010, "R3");
    step(1, 16'h8103, 3'b000, "R5");

    // R3, R4: pattern wake with enable off
    step(1, 16'h0003, 3'b000, "R2");
    step(0, 16'h0000, 3'b100, "R3");
    check("R4", "disabled out high", int'(pmeWake_n), 1);
    check("R3", "status set while disabled", int'(regRdData[15]), 1);
    step(1, 16'h0103, 3'b000, "R4");
    // R5: writing zero leaves status
    step(1, 16'h0103, 3'b000, "R5");
    check("R5", "zero write keeps status", int'(regRdData[15]), 1);

    // R6: wake together with clear
    step(1, 16'h8103, 3'b001, "R6");
    check("R6", "wake beats clear", int'(regRdData[15]), 1);
    step(1, 16'h8103, 3'b110, "R6");

    // R8: clear and return to fully-on in one write
    step(1, 16'h8100, 3'b000, "R8");
    check("R8", "joint clear word", int'(regRdData), 16'h0100);

    // R7: unsupported codes
    step(1, 16'h0101, 3'b000, "R7");
    check("R7", "lite1 ignored", int'(powerState), 0);
    step(1, 16'h0102, 3'b000, "R7");
    step(1, 16'h0103, 3'b000, "R7");
    step(1, 16'h0101, 3'b000, "R7");
    check("R7", "stays deep", int'(powerState), 3);

    // R8: state change alone keeps status
    step(0, 16'h0000, 3'b111, "R3");
    step(1, 16'h0100, 3'b000, "R8");
    check("R8", "status kept across state write", int'(regRdData[15]), 1);
    step(1, 16'h0103, 3'b000, "R8");

    // R9: reserved bits
    step(1, 16'h7EFF, 3'b000, "R9");
    check("R9", "reserved zero", int'(regRdData & 16'h7EFC), 0);
    step(1, 16'hFFFF, 3'b000, "R9");
    step(0, 16'h0000, 3'b000, "R4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule